// File: doc/BRIEF.md
# Low-Power Lane Turnaround Controller

This block hands ownership of a bidirectional data lane back and forth while the lane runs in low-power signalling. The controller does both roles. As owner it can give the lane away. As listener it can take the lane over. It drives a two-bit low-power line state with an output enable, watches the sampled line state from the far end, and reports which side currently owns the lane. Every phase length is a whole multiple of one programmable low-power unit, written LPX below and given in clock cycles.

As owner the block idles in the stop state LP-11. A turnaround request makes it signal LP-10 and then LP-00. It holds the bridge state LP-00 for its full give-away time and then releases the line. As listener it arms once it has seen LP-11 on the line. An LP-10 from the far end starts a bounded wait. After the wait the block drives LP-00 for the take-over time, then LP-10, and then settles in LP-11 as the new owner. A line state that does not belong in the wait cancels the takeover and raises a one-cycle error pulse.

Top module: `lp_turnaround_ctrl`

## Requirements
- R1: After reset with the default owner setting, `dir_o`=1, `oe_o`=1, `lp_o`=2'b11 (LP-11) and `err_o`=0. Line codes are {p,n}: 11=LP-11, 10=LP-10, 01=LP-01, 00=LP-00.
- R2: `turn_req_i` is acted on only while the block owns the lane in LP-11 and `line_i` reads 2'b11. Otherwise it has no effect: an owner stays in LP-11 with `dir_o`=1, and a listener keeps `oe_o`=0.
- R3: A request that is accepted drives LP-10 for exactly L cycles. It then drives LP-00 for exactly 5L cycles: one L of entry followed by a 4L bridge. L is `lpx_cycles_i`.
- R4: In the cycle after the bridge ends, `oe_o` and `dir_o` are both 0.
- R5: After a release, or after an aborted takeover, the listener ignores LP-10 until `line_i` has read LP-11 at least once.
- R6: An armed listener that sees LP-10 keeps `oe_o`=0 for exactly L+floor(L/2) cycles. It then drives LP-00 for exactly 5L cycles.
- R7: After that LP-00 it drives LP-10 for exactly L cycles. It then drives LP-11, and `dir_o` rises in the same cycle.
- R8: During the wait, `line_i` at LP-11 or LP-01 cancels the takeover. `err_o` is high for exactly one cycle, the line stays undriven, and the block returns to listening.
- R9: `lpx_cycles_i`=0 is treated as L=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lpx_cycles_i | input | CW | LPX length in clock cycles |
| turn_req_i | input | 1 | Request to hand the lane to the far end |
| line_i | input | 2 | Sampled low-power line state {p,n} |
| lp_o | output | 2 | Driven low-power line state {p,n} |
| oe_o | output | 1 | Line driver enable |
| dir_o | output | 1 | 1 while this side owns the lane |
| err_o | output | 1 | One-cycle pulse when a takeover is cancelled |

## Verification
A full round trip (release, then takeover) is run for LPX values of 1, 2, 3 and 5, and for 0. The spread of values checks that each phase scales with its own multiple of L, and that the floor in the wait length is applied for both odd and even L. The zero value checks that it is clamped to 1. Directed cases then try to get each transition started by the wrong pattern:
- a request while the line is not idle;
- a request while listening;
- LP-10 before the line has returned to idle;
- LP-11 during the wait;
- LP-01 during the wait.

Each of these cases checks whether the block rejects the pattern or aborts cleanly.

// File: rtl/lpta_pkg.sv
package lpta_pkg;
  typedef enum logic [3:0] {
    ST_OWN, ST_REQ, ST_PRE, ST_GO, ST_WSTOP, ST_LISTEN, ST_SURE, ST_GET, ST_ACK
  } lpta_st_e;

  localparam logic [1:0] LP11 = 2'b11;
  localparam logic [1:0] LP10 = 2'b10;
  localparam logic [1:0] LP01 = 2'b01;
  localparam logic [1:0] LP00 = 2'b00;
endpackage

// File: rtl/lpta_len.sv
module lpta_len
  import lpta_pkg::*;
#(
  parameter int CW = 16,
  parameter int TW = CW + 3
) (
  input  logic [CW-1:0] lpx_i,
  input  lpta_st_e      st_i,
  output logic [TW-1:0] len_o
);
  logic [TW-1:0] l_ext;

  always_comb begin
    l_ext = (lpx_i == '0) ? TW'(1) : TW'(lpx_i);  // R9 clamp
    unique case (st_i)
      ST_REQ, ST_PRE, ST_ACK: len_o = l_ext;
      ST_GO:                  len_o = l_ext << 2;
      ST_GET:                 len_o = (l_ext << 2) + l_ext;
      ST_SURE:                len_o = l_ext + (l_ext >> 1);
      default:                len_o = TW'(1);
    endcase
  end
endmodule

// File: rtl/lpta_timer.sv
module lpta_timer #(
  parameter int TW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [TW-1:0] len_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (ld_i)          cnt_q <= len_i - TW'(1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = (cnt_q == '0);

  a_r3_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |-> len_i != '0);
endmodule

// File: rtl/lpta_fsm.sv
module lpta_fsm
  import lpta_pkg::*;
#(
  parameter bit INIT_OWNER = 1'b1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic [1:0] line_i,
  input  logic     done_i,
  output lpta_st_e st_o,
  output lpta_st_e nxt_o,
  output logic     ld_o,
  output logic     err_o
);
  localparam lpta_st_e RST_ST = INIT_OWNER ? ST_OWN : ST_WSTOP;

  lpta_st_e st_q, nxt;
  logic     bad, err_q;

  assign bad = (line_i != LP10) && (line_i != LP00);

  always_comb begin
    nxt = st_q;
    unique case (st_q)
      ST_OWN:    if (req_i && line_i == LP11) nxt = ST_REQ;
      ST_REQ:    if (done_i) nxt = ST_PRE;
      ST_PRE:    if (done_i) nxt = ST_GO;
      ST_GO:     if (done_i) nxt = ST_WSTOP;
      ST_WSTOP:  if (line_i == LP11) nxt = ST_LISTEN;
      ST_LISTEN: if (line_i == LP10) nxt = ST_SURE;
      ST_SURE:   if (bad) nxt = ST_WSTOP;
                 else if (done_i) nxt = ST_GET;
      ST_GET:    if (done_i) nxt = ST_ACK;
      ST_ACK:    if (done_i) nxt = ST_OWN;
      default:   nxt = RST_ST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RST_ST;
      err_q <= 1'b0;
    end else begin
      st_q  <= nxt;
      err_q <= (st_q == ST_SURE) && bad;
    end
  end

  assign st_o  = st_q;
  assign nxt_o = nxt;
  assign ld_o  = (nxt != st_q);
  assign err_o = err_q;

  a_r8_abort_to_listen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SURE && bad) |=> st_q == ST_WSTOP);
endmodule

// File: rtl/lp_turnaround_ctrl.sv
module lp_turnaround_ctrl
  import lpta_pkg::*;
#(
  parameter int CW         = 16,
  parameter bit INIT_OWNER = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] lpx_cycles_i,
  input  logic          turn_req_i,
  input  logic [1:0]    line_i,
  output logic [1:0]    lp_o,
  output logic          oe_o,
  output logic          dir_o,
  output logic          err_o
);
  localparam int TW = CW + 3;  // room for 5*LPX

  lpta_st_e      st, nxt;
  logic          ld, done;
  logic [TW-1:0] len;

  lpta_fsm #(.INIT_OWNER(INIT_OWNER)) u_fsm (
    .clk_i, .rst_ni, .req_i(turn_req_i), .line_i, .done_i(done),
    .st_o(st), .nxt_o(nxt), .ld_o(ld), .err_o
  );

  lpta_len #(.CW(CW), .TW(TW)) u_len (
    .lpx_i(lpx_cycles_i), .st_i(nxt), .len_o(len)
  );

  lpta_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .ld_i(ld), .len_i(len), .done_o(done)
  );

  always_comb begin
    unique case (st)
      ST_REQ, ST_ACK:        lp_o = LP10;
      ST_PRE, ST_GO, ST_GET: lp_o = LP00;
      default:               lp_o = LP11;
    endcase
    oe_o  = st inside {ST_OWN, ST_REQ, ST_PRE, ST_GO, ST_GET, ST_ACK};
    dir_o = st inside {ST_OWN, ST_REQ, ST_PRE, ST_GO};
  end

  a_r2_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_o && lp_o == LP11 && turn_req_i && line_i != LP11) |=> (dir_o && lp_o == LP11));
  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_o && lp_o == LP11 && turn_req_i && line_i == LP11) |=> lp_o == LP10);
  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> (!dir_o && $past(lp_o) == LP00));
  a_r6_take_bridge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> (lp_o == LP00 && !dir_o));
  a_r7_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dir_o) |-> (lp_o == LP11 && $past(lp_o) == LP10));
  a_r8_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r8_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !oe_o);
endmodule

// File: tb/sim_lp_turnaround_ctrl.sv
module sim_lp_turnaround_ctrl;
  localparam int TCLK = 10;
  localparam int CW   = 16;
  // {lpx, exp LP-10 run, exp LP-00 run (5L), exp wait}
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{1, 1, 5, 1}, '{2, 2, 10, 3}, '{3, 3, 15, 4}, '{5, 5, 25, 7}, '{0, 1, 5, 1}
  };

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [CW-1:0] lpx;
  logic          req;
  logic [1:0]    line;
  logic [1:0]    lp_o;
  logic          oe_o, dir_o, err_o;
  int            n_chk = 0, n_fail = 0;

  always #(TCLK/2) clk = ~clk;

  lp_turnaround_ctrl #(.CW(CW)) u0 (
    .clk_i(clk), .rst_ni, .lpx_cycles_i(lpx), .turn_req_i(req), .line_i(line),
    .lp_o, .oe_o, .dir_o, .err_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_len(input logic [1:0] v, input logic want_oe, output int n);
    n = 0;
    while (lp_o == v && oe_o == want_oe && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    rst_ni = 1'b0; req = 1'b0; line = 2'b11; lpx = CW'(2);
    repeat (3) @(negedge clk);
    chk(dir_o && oe_o && lp_o == 2'b11 && !err_o, "R1 reset", {dir_o, oe_o, lp_o, err_o}, 5'b11110);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(dir_o && oe_o && lp_o == 2'b11, "R1 after reset", {dir_o, oe_o, lp_o}, 4'b1111);

    // R2: request while line not idle is dropped
    line = 2'b01; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    chk(dir_o && lp_o == 2'b11, "R2 busy line ignored", lp_o, 3);
    line = 2'b11;

    for (int i = 0; i < NV; i++) begin
      lpx = CW'(VEC[i][0]);
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0; line = 2'b00;
      run_len(2'b10, 1'b1, n);
      chk(n == VEC[i][1], "R3/R9 release LP-10 length", n, VEC[i][1]);
      run_len(2'b00, 1'b1, n);
      chk(n == VEC[i][2], "R3/R9 release LP-00 length", n, VEC[i][2]);
      chk(!oe_o && !dir_o, "R4 released", {oe_o, dir_o}, 0);
      line = 2'b10;
      repeat (3) @(negedge clk);
      chk(!oe_o, "R5 LP-10 before idle ignored", oe_o, 0);
      line = 2'b11;
      repeat (2) @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(!oe_o && !dir_o, "R2 request while listening ignored", oe_o, 0);
      line = 2'b10;
      @(negedge clk);
      n = 0;
      while (!oe_o && n < 1000) begin
        n++;
        @(negedge clk);
      end
      chk(n == VEC[i][3], "R6 wait length", n, VEC[i][3]);
      line = 2'b11;
      run_len(2'b00, 1'b1, n);
      chk(n == VEC[i][2], "R6 take LP-00 length", n, VEC[i][2]);
      run_len(2'b10, 1'b1, n);
      chk(n == VEC[i][1], "R7 take LP-10 length", n, VEC[i][1]);
      chk(dir_o && lp_o == 2'b11 && oe_o, "R7 owner in LP-11", {dir_o, lp_o}, 7);
    end

    // R8: aborts during the wait
    lpx = CW'(3);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0; line = 2'b00;
    n = 0;
    while (oe_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
    line = 2'b11;
    repeat (2) @(negedge clk);
    line = 2'b10;
    @(negedge clk);
    line = 2'b11;
    @(negedge clk);
    chk(err_o && !oe_o, "R8 LP-11 abort pulse", {err_o, oe_o}, 2);
    @(negedge clk);
    chk(!err_o && !oe_o, "R8 pulse one cycle", {err_o, oe_o}, 0);
    line = 2'b10;
    @(negedge clk);
    line = 2'b01;
    @(negedge clk);
    chk(err_o && !oe_o, "R8 LP-01 abort pulse", {err_o, oe_o}, 2);
    line = 2'b10;
    repeat (6) @(negedge clk);
    chk(!oe_o && !err_o, "R5 LP-10 after abort ignored until idle", oe_o, 0);
    line = 2'b11;
    repeat (2) @(negedge clk);
    line = 2'b10;
    n = 0;
    while (!dir_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(dir_o && lp_o == 2'b11, "R8 takeover after recovery", dir_o, 1);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule